// File: doc/BRIEF.md
# CAM Entry Validity and Address Control

This block is a small content-addressable memory whose entries each carry an active-low validity bit. A command path takes a 12-bit opcode with a direction strobe. It sets or clears validity at the entry named by an address register, and it steps that register up or down. It can also clear the entries flagged by the most recent compare. That clear works either on the single lowest-address hit or on every hit. A second bit per entry forms an independent table that software can set, clear and read. Any single bit read back appears on data line 0 of a 32-bit bus.

Compare and fill requests arrive on their own strobes and share one key input. A compare checks the key against every valid entry. It latches the per-entry hit flags, a flag that says whether anything hit, and the lowest hit address. Later clear commands act on that latched result. A fill request stores the key into the lowest-address empty entry and marks that entry valid. A valid entry is never overwritten. Only one action runs per clock.

Top module: `cam_valid_ctl`

## Requirements
- R1: After reset every validity bit and every table bit reads 1 (empty / invalid), the address register is 0, match_any is 0, match_addr is 0, full is 0 and rd_data is 0.
- R2: A write command (cmd_wr=1) with cmd_op[5:0]=100000 clears the validity bit of the entry at the address register (marks it valid). A read command (cmd_wr=0) with the same code places that entry's validity bit on rd_data[0] one cycle later, with rd_data[31:1]=0.
- R3: A write command with cmd_op[5:0]=100001 sets the validity bit of the entry at the address register to 1 (empty).
- R4: The cycle after a compare, match_any tells whether any valid entry equals the key, and match_addr holds the lowest such address (0 when none). Empty entries never hit. The latched result holds until the next compare.
- R5: A write command with cmd_op[5:0]=100010 marks empty the entry at match_addr when match_any is 1. When match_any is 0 it changes nothing.
- R6: A write command with cmd_op[5:0]=100011 marks empty every entry that hit in the latched compare result.
- R7: A fill request stores the key in the lowest-address empty entry and marks it valid. Output full is 1 exactly when no entry is empty, and while full a fill changes nothing.
- R8: A write command with cmd_op[5:0]=100100 increments the address register, and 100101 decrements it. Both wrap modulo ENTRIES.
- R9: A write command with cmd_op[5:0]=101000 clears the table bit at the address register, and 101001 sets it. A read command with 101000 returns that bit on rd_data[0] one cycle later, with the upper bits 0.
- R10: cmd_op[11:6] is ignored. Any other low code, or a read with a code other than 100000 or 101000, changes no state and gives rd_data=0 the next cycle.
- R11: In one cycle a command (cmd_en) takes precedence over a compare (cmp_go), which takes precedence over a fill (wnf_go). The losers are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_en | input | 1 | Command strobe |
| cmd_wr | input | 1 | 1 = write/action command, 0 = read command |
| cmd_op | input | 12 | Opcode, low six bits decoded |
| cmp_go | input | 1 | Compare request |
| wnf_go | input | 1 | Fill-next-empty request |
| key_in | input | KEY_W | Key for compare and fill |
| rd_data | output | 32 | Readback bus, bit in position 0 |
| addr_reg | output | AW | Address register |
| match_any | output | 1 | Previous compare found a hit |
| match_addr | output | AW | Lowest hit address of previous compare |
| full | output | 1 | No empty entry remains |

## Verification
The bench builds the block with ENTRIES=12 and KEY_W=8. An entry count that is not a power of two puts the explicit wrap of the address register in reach at both ends, where natural overflow would not reach it. The bench draws keys from only four values. This makes multiple hits, lowest-address priority and the clear-all-hits path occur often in random traffic. Twelve entries also let fill traffic reach the full state quickly.

// File: rtl/cam_valid_ctl.sv
module cam_valid_ctl #(
  parameter int ENTRIES = 16,
  parameter int KEY_W = 32,
  localparam int AW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_en,
  input  logic             cmd_wr,
  input  logic [11:0]      cmd_op,
  input  logic             cmp_go,
  input  logic             wnf_go,
  input  logic [KEY_W-1:0] key_in,
  output logic [31:0]      rd_data,
  output logic [AW-1:0]    addr_reg,
  output logic             match_any,
  output logic [AW-1:0]    match_addr,
  output logic             full
);

  localparam logic [5:0] OP_VAL  = 6'b100000;
  localparam logic [5:0] OP_EMP  = 6'b100001;
  localparam logic [5:0] OP_HPM  = 6'b100010;
  localparam logic [5:0] OP_AML  = 6'b100011;
  localparam logic [5:0] OP_INC  = 6'b100100;
  localparam logic [5:0] OP_DEC  = 6'b100101;
  localparam logic [5:0] OP_TVAL = 6'b101000;
  localparam logic [5:0] OP_TINV = 6'b101001;
  localparam logic [AW-1:0] TOP = AW'(ENTRIES - 1);

  logic [KEY_W-1:0]   mem [ENTRIES];
  logic [ENTRIES-1:0] vbit, tbit, match_q, hit_vec;
  logic [AW-1:0]      ar, hpm_q, hit_idx, free_idx;
  logic               any_q, free_found;
  logic [31:0]        rd_q;

  wire [5:0] op     = cmd_op[5:0];
  wire       wr_cmd = cmd_en & cmd_wr;
  wire       rd_cmd = cmd_en & ~cmd_wr;
  wire       do_cmp = cmp_go & ~cmd_en;
  wire       do_wnf = wnf_go & ~cmd_en & ~cmp_go;

  assign rd_data    = rd_q;
  assign addr_reg   = ar;
  assign match_any  = any_q;
  assign match_addr = hpm_q;
  assign full       = ~|vbit;

  always_comb begin
    hit_idx    = '0;
    free_idx   = '0;
    free_found = 1'b0;
    for (int i = 0; i < ENTRIES; i++)
      hit_vec[i] = ~vbit[i] && (mem[i] == key_in);
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx = AW'(i);
      if (vbit[i]) begin
        free_idx   = AW'(i);
        free_found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_wnf && free_found) mem[free_idx] <= key_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vbit    <= '1;
      tbit    <= '1;
      ar      <= '0;
      match_q <= '0;
      any_q   <= 1'b0;
      hpm_q   <= '0;
      rd_q    <= '0;
    end else begin
      rd_q <= '0;
      if (rd_cmd) begin
        case (op)
          OP_VAL:  rd_q <= {31'b0, vbit[ar]};
          OP_TVAL: rd_q <= {31'b0, tbit[ar]};
          default: ;
        endcase
      end else if (wr_cmd) begin
        case (op)
          OP_VAL:  vbit[ar] <= 1'b0;
          OP_EMP:  vbit[ar] <= 1'b1;
          OP_HPM:  if (any_q) vbit[hpm_q] <= 1'b1;
          OP_AML:  vbit <= vbit | match_q;
          OP_INC:  ar <= (ar == TOP) ? '0 : ar + 1'b1;
          OP_DEC:  ar <= (ar == '0) ? TOP : ar - 1'b1;
          OP_TVAL: tbit[ar] <= 1'b0;
          OP_TINV: tbit[ar] <= 1'b1;
          default: ;
        endcase
      end else if (do_cmp) begin
        match_q <= hit_vec;
        any_q   <= |hit_vec;
        hpm_q   <= hit_idx;
      end else if (do_wnf && free_found) begin
        vbit[free_idx] <= 1'b0;
      end
    end
  end

  // R8
  ar_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && op == OP_INC) |=> addr_reg == (($past(addr_reg) == TOP) ? '0 : $past(addr_reg) + 1'b1));

  // R8
  ar_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && op == OP_DEC) |=> addr_reg == (($past(addr_reg) == '0) ? TOP : $past(addr_reg) - 1'b1));

  // R4
  hpm_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_any |-> match_q[match_addr]);

  // R4
  no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !match_any |-> (match_q == '0 && match_addr == '0));

  // R7
  wnf_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_wnf && !full) |=> !vbit[$past(free_idx)]);

  // R3
  set_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && op == OP_EMP) |=> vbit[$past(addr_reg)]);

  // R6
  aml_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && op == OP_AML) |=> ((vbit & $past(match_q)) == $past(match_q)));

  // R2
  rd_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[0] |-> $past(rd_cmd));

endmodule

// File: tb/sim_cam_valid_ctl.sv
module sim_cam_valid_ctl;
  localparam int N = 12;
  localparam int KW = 8;
  localparam int AW = $clog2(N);

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_en = 0, cmd_wr = 0, cmp_go = 0, wnf_go = 0;
  logic [11:0] cmd_op = '0;
  logic [KW-1:0] key_in = '0;
  logic [31:0] rd_data;
  logic [AW-1:0] addr_reg, match_addr;
  logic match_any, full;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  logic r_v[N], r_t[N], r_hit[N];
  logic [KW-1:0] r_mem[N];
  int r_ar = 0, r_hpm = 0;
  logic r_any = 0;
  logic [31:0] e_rd = '0;

  cam_valid_ctl #(.ENTRIES(N), .KEY_W(KW)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_en(cmd_en), .cmd_wr(cmd_wr), .cmd_op(cmd_op),
    .cmp_go(cmp_go), .wnf_go(wnf_go), .key_in(key_in), .rd_data(rd_data),
    .addr_reg(addr_reg), .match_any(match_any), .match_addr(match_addr), .full(full));

  always #10 clk = ~clk;

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000 && !done) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cyc);
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
      end
    end
  end

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int lowest_free();
    for (int i = 0; i < N; i++) if (r_v[i]) return i;
    return -1;
  endfunction

  function automatic int wrap_step(input int a, input bit up);
    if (up) return (a == N - 1) ? 0 : a + 1;
    return (a == 0) ? N - 1 : a - 1;
  endfunction

  function automatic bit model_full();
    for (int i = 0; i < N; i++) if (r_v[i]) return 0;
    return 1;
  endfunction

  task automatic model(input logic en, input logic wr, input logic [5:0] lo,
                       input logic cg, input logic wg, input logic [KW-1:0] k);
    e_rd = '0;
    if (en && !wr) begin
      if (lo == 6'b100000) e_rd = {31'b0, r_v[r_ar]};
      else if (lo == 6'b101000) e_rd = {31'b0, r_t[r_ar]};
    end else if (en) begin
      case (lo)
        6'b100000: r_v[r_ar] = 0;
        6'b100001: r_v[r_ar] = 1;
        6'b100010: if (r_any) r_v[r_hpm] = 1;
        6'b100011: for (int i = 0; i < N; i++) if (r_hit[i]) r_v[i] = 1;
        6'b100100: r_ar = wrap_step(r_ar, 1);
        6'b100101: r_ar = wrap_step(r_ar, 0);
        6'b101000: r_t[r_ar] = 0;
        6'b101001: r_t[r_ar] = 1;
        default: ;
      endcase
    end else if (cg) begin
      r_any = 0; r_hpm = 0;
      for (int i = N - 1; i >= 0; i--) begin
        r_hit[i] = !r_v[i] && r_mem[i] == k;
        if (r_hit[i]) begin r_any = 1; r_hpm = i; end
      end
    end else if (wg) begin
      int f = lowest_free();
      if (f >= 0) begin r_mem[f] = k; r_v[f] = 0; end
    end
  endtask

  task automatic step(input string tag, input logic en, input logic wr, input logic [11:0] op,
                      input logic cg, input logic wg, input logic [KW-1:0] k);
    cmd_en = en; cmd_wr = wr; cmd_op = op; cmp_go = cg; wnf_go = wg; key_in = k;
    @(posedge clk);
    model(en, wr, op[5:0], cg, wg, k);
    @(negedge clk);
    cmd_en = 0; cmp_go = 0; wnf_go = 0;
    check(tag, "rd_data", rd_data, e_rd);
    check("R8", "addr_reg", addr_reg, r_ar);
    check("R4", "match_any", match_any, r_any);
    check("R4", "match_addr", match_addr, r_hpm);
    check("R7", "full", full, model_full());
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < N; i++) begin
      step(tag, 1, 0, {6'($urandom), 6'b100000}, 0, 0, '0);
      step(tag, 1, 0, {6'($urandom), 6'b101000}, 0, 0, '0);
      step("R8", 1, 1, 12'h024, 0, 0, '0);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_c4a1));
    for (int i = 0; i < N; i++) begin r_v[i] = 1; r_t[i] = 1; r_hit[i] = 0; r_mem[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1", "rd_data", rd_data, 0);
    check("R1", "addr_reg", addr_reg, 0);
    check("R1", "match_any", match_any, 0);
    check("R1", "full", full, 0);
    sweep("R1");

    step("R8", 1, 1, 12'h025, 0, 0, '0);
    step("R8", 1, 1, 12'h024, 0, 0, '0);

    step("R5", 1, 1, 12'h022, 0, 0, '0);
    for (int i = 0; i < N; i++) step("R7", 0, 0, 12'h000, 0, 1, KW'(i % 3));
    step("R7", 0, 0, 12'h000, 0, 1, 8'h77);
    step("R4", 0, 0, 12'h000, 1, 0, 8'd1);
    step("R5", 1, 1, 12'hFE2, 0, 0, '0);
    step("R4", 0, 0, 12'h000, 1, 0, 8'd1);
    step("R6", 1, 1, 12'h023, 0, 0, '0);
    sweep("R6");
    step("R11", 1, 1, 12'h024, 1, 1, 8'd0);
    step("R11", 0, 0, 12'h000, 1, 1, 8'd2);
    step("R10", 1, 1, 12'hFFF, 0, 0, '0);
    step("R10", 1, 0, 12'h024, 0, 0, '0);
    step("R3", 1, 1, 12'h021, 0, 0, '0);
    step("R9", 1, 1, 12'h028, 0, 0, '0);
    sweep("R9");

    for (int n = 0; n < 4000; n++) begin
      int sel = $urandom % 16;
      logic [5:0] hi = 6'($urandom);
      logic [KW-1:0] k = KW'($urandom % 4);
      logic [5:0] lo;
      case (sel)
        0: lo = 6'b100000; 1: lo = 6'b100001; 2: lo = 6'b100010; 3: lo = 6'b100011;
        4, 5: lo = 6'b100100; 6: lo = 6'b100101; 7: lo = 6'b101000; 8: lo = 6'b101001;
        default: lo = 6'($urandom);
      endcase
      if (sel < 10) begin
        logic w = ($urandom % 3) != 0;
        string t;
        if (!w && lo == 6'b100000) t = "R2";
        else if (!w && lo == 6'b101000) t = "R9";
        else t = "R10";
        step(t, 1, w, {hi, lo}, $urandom % 2, $urandom % 2, k);
      end else if (sel < 13) begin
        step("R4", 0, 0, '0, 1, $urandom % 2, k);
      end else begin
        step("R7", 0, 0, '0, 0, 1, k);
      end
    end
    sweep("R2");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule